// File: doc/BRIEF.md
# Cycle Timer and Interrupt Control Slice

This block is the timer and interrupt part of a processor's system-control register file. The core addresses four 32-bit registers through one select port: a free-running cycle counter, a match value, a mode register (enables, masks, exception-level flag) and a reason register (pending lines, counter stop flag, vector choice). A write happens on the clock edge. A read returns the selected register combinationally in the same cycle.

The counter advances once per clock, not once per retired instruction, so its value depends on stalls and memory latency. A stop flag in the reason register freezes it. When the counter equals the match value while counting, a timer pending bit is latched. It stays set until software writes the match register. The block combines the pending bits with the mode register's mask and enables into a single interrupt request for the pipeline. It also supplies the vector offset the pipeline should jump to.

After reset the counter is stopped, the core is at exception level with every interrupt disabled, and the separate interrupt vector is selected.

Top module: `sctl_timer_irq`

## Requirements
- R1: Reset values: mode (select 12) reads 0x10000002, reason (select 13) reads 0x0880007C, counter (select 9) reads 0, match (select 11) reads 0, irq_req is 0.
- R2: Selects 9, 11, 12 and 13 read their register in the same cycle. Any other select reads 0, and a write to it changes no register.
- R3: The counter increments by one on each clock while reason bit 27 is 0 and holds while it is 1. That bit takes effect on the edge after the reason write.
- R4: A counter write loads the written value and takes priority over the increment in the same cycle.
- R5: Software writes to the reason register change only bit 27 (stop counter), bit 23 (separate vector) and bits 9:8 (software interrupts). Every other reason bit keeps its value.
- R6: Reason bit 15 (timer pending) is set on the edge after a cycle in which the counter equals the match value while counting. It stays set until the match register is written.
- R7: Any write to the match register clears the timer pending bit, even if a match occurs in the same cycle.
- R8: irq_req is 1 exactly when mode bit 0 (enable) is 1, mode bit 1 (exception level) is 0, and reason[15:8] AND mode[15:8] is nonzero.
- R9: irq_vec_off is 0x200 while reason bit 23 is 1 and 0x180 while it is 0.
- R10: All bits of the mode register are writable and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 5 | Register number for read and write |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, same cycle |
| irq_req | output | 1 | Combined interrupt request to the pipeline |
| irq_vec_off | output | 12 | Exception vector offset for an interrupt |

## Verification
Some rules are checked on every cycle, from the register state and the write port alone: counter increment and hold, write priority over increment, reason bits outside the writable mask, persistence and clearing of the timer pending bit, and suppression of the request at exception level. Other behaviour is shown only by the bench's scenarios. These cover the exact cycle the pending bit appears after a counter-match sequence, a match write that coincides with a match, read values and the vector offset for each register state, and the fact that unmapped selects neither read nor write anything.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
   // one-hot write strobes derived from the register select
   typedef struct packed {
      logic cnt;
      logic cmp;
      logic mode;
      logic why;
   } sctl_wstb_t;
endpackage

// File: rtl/sctl_tick.sv
module sctl_tick #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              ld,
   input  logic [DATA_W-1:0] ld_val,
   output logic [DATA_W-1:0] count
);
   localparam logic [DATA_W-1:0] STEP = {{(DATA_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (ld)  count <= ld_val;
      else if (run) count <= count + STEP;
   end
endmodule

// File: rtl/sctl_match.sv
module sctl_match #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [DATA_W-1:0] count,
   input  logic              cmp_we,
   input  logic [DATA_W-1:0] cmp_wdata,
   output logic [DATA_W-1:0] cmp_q,
   output logic              pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q <= '0;
      else if (cmp_we) cmp_q <= cmp_wdata;
   end

   // clear by write wins over a coincident match
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       pend <= 1'b0;
      else if (cmp_we)                  pend <= 1'b0;
      else if (run && (count == cmp_q)) pend <= 1'b1;
   end
endmodule

// File: rtl/sctl_irq.sv
module sctl_irq #(
   parameter int          NLINE     = 8,
   parameter int          VEC_W     = 12,
   parameter bit          VEC_SPLIT = 1'b1,
   parameter logic [11:0] VEC_IRQ   = 12'h200,
   parameter logic [11:0] VEC_GEN   = 12'h180
) (
   input  logic             ie,
   input  logic             exl,
   input  logic [NLINE-1:0] ip,
   input  logic [NLINE-1:0] im,
   input  logic             vsel,
   output logic             irq,
   output logic [VEC_W-1:0] vec_off
);
   assign irq = ie && !exl && (|(ip & im));

   if (VEC_SPLIT) begin : g_split
      assign vec_off = vsel ? VEC_W'(VEC_IRQ) : VEC_W'(VEC_GEN);
   end else begin : g_shared
      assign vec_off = VEC_W'(VEC_GEN);
   end
endmodule

// File: rtl/sctl_timer_irq.sv
module sctl_timer_irq #(
   parameter int          DATA_W    = 32,
   parameter int          SEL_W     = 5,
   parameter int          VEC_W     = 12,
   parameter int          SEL_CNT   = 9,
   parameter int          SEL_CMP   = 11,
   parameter int          SEL_MODE  = 12,
   parameter int          SEL_WHY   = 13,
   parameter logic [31:0] MODE_RST  = 32'h1000_0002,
   parameter logic [31:0] WHY_RST   = 32'h0880_007C,
   parameter int          STOP_BIT  = 27,
   parameter int          VSEL_BIT  = 23,
   parameter int          TMR_BIT   = 15,
   parameter int          LINE_LO   = 8,
   parameter int          LINE_HI   = 15,
   parameter int          SW_BITS   = 2,
   parameter int          IE_BIT    = 0,
   parameter int          EXL_BIT   = 1,
   parameter bit          VEC_SPLIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vec_off
);
   import sctl_pkg::*;

   localparam int NLINE = LINE_HI - LINE_LO + 1;
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [DATA_W-1:0] SW_MASK  = ((ONE << SW_BITS) - ONE) << LINE_LO;
   localparam logic [DATA_W-1:0] WHY_WMASK =
      (ONE << STOP_BIT) | (ONE << VSEL_BIT) | SW_MASK;
   localparam logic [DATA_W-1:0] WHY_INIT = DATA_W'(WHY_RST) & ~(ONE << TMR_BIT);

   // elaboration-time parameter checks
   if (DATA_W < 32)
      $error("sctl_timer_irq: DATA_W must be at least 32");
   if (VEC_W < 12)
      $error("sctl_timer_irq: VEC_W must hold the vector offsets");
   if (LINE_HI < LINE_LO || TMR_BIT < LINE_LO || TMR_BIT > LINE_HI)
      $error("sctl_timer_irq: timer line outside pending field");
   if (SW_BITS < 1 || LINE_LO + SW_BITS > TMR_BIT)
      $error("sctl_timer_irq: software lines overlap timer line");
   if ((1 << SEL_W) <= SEL_WHY)
      $error("sctl_timer_irq: SEL_W too narrow for register numbers");

   sctl_wstb_t        wstb;
   logic [DATA_W-1:0] count_q;
   logic [DATA_W-1:0] cmp_q;
   logic [DATA_W-1:0] mode_q;
   logic [DATA_W-1:0] why_q;
   logic [DATA_W-1:0] why_rd;
   logic              cmp_pend;
   logic              run;

   // write strobe decode
   always_comb begin
      wstb      = '0;
      wstb.cnt  = reg_we && (reg_sel == SEL_W'(SEL_CNT));
      wstb.cmp  = reg_we && (reg_sel == SEL_W'(SEL_CMP));
      wstb.mode = reg_we && (reg_sel == SEL_W'(SEL_MODE));
      wstb.why  = reg_we && (reg_sel == SEL_W'(SEL_WHY));
   end

   // mode register: fully writable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode_q <= DATA_W'(MODE_RST);
      else if (wstb.mode) mode_q <= reg_wdata;
   end

   // reason register: only masked bits follow software
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        why_q <= WHY_INIT;
      else if (wstb.why) why_q <= (why_q & ~WHY_WMASK) | (reg_wdata & WHY_WMASK);
   end

   assign run = !why_q[STOP_BIT];

   sctl_tick #(.DATA_W(DATA_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .ld     (wstb.cnt),
      .ld_val (reg_wdata),
      .count  (count_q)
   );

   sctl_match #(.DATA_W(DATA_W)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .count     (count_q),
      .cmp_we    (wstb.cmp),
      .cmp_wdata (reg_wdata),
      .cmp_q     (cmp_q),
      .pend      (cmp_pend)
   );

   // reason as seen by software: hardware timer line inserted
   always_comb begin
      why_rd          = why_q;
      why_rd[TMR_BIT] = cmp_pend;
   end

   sctl_irq #(
      .NLINE     (NLINE),
      .VEC_W     (VEC_W),
      .VEC_SPLIT (VEC_SPLIT)
   ) u_irq (
      .ie      (mode_q[IE_BIT]),
      .exl     (mode_q[EXL_BIT]),
      .ip      (why_rd[LINE_HI:LINE_LO]),
      .im      (mode_q[LINE_HI:LINE_LO]),
      .vsel    (why_q[VSEL_BIT]),
      .irq     (irq_req),
      .vec_off (irq_vec_off)
   );

   // same-cycle read mux
   always_comb begin
      if (reg_sel == SEL_W'(SEL_CNT))       reg_rdata = count_q;
      else if (reg_sel == SEL_W'(SEL_CMP))  reg_rdata = cmp_q;
      else if (reg_sel == SEL_W'(SEL_MODE)) reg_rdata = mode_q;
      else if (reg_sel == SEL_W'(SEL_WHY))  reg_rdata = why_rd;
      else                                  reg_rdata = '0;
   end
endmodule

// File: rtl/sctl_timer_irq_chk.sv
module sctl_timer_irq_chk #(
   parameter int DATA_W   = 32,
   parameter int SEL_W    = 5,
   parameter int SEL_CNT  = 9,
   parameter int SEL_CMP  = 11,
   parameter int STOP_BIT = 27,
   parameter int VSEL_BIT = 23,
   parameter int LINE_LO  = 8,
   parameter int SW_BITS  = 2,
   parameter int IE_BIT   = 0,
   parameter int EXL_BIT  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SEL_W-1:0]  reg_sel,
   input logic              reg_we,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              irq_req,
   input logic [DATA_W-1:0] count_q,
   input logic [DATA_W-1:0] why_q,
   input logic [DATA_W-1:0] mode_q,
   input logic              cmp_pend
);
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [DATA_W-1:0] KEEP = ~((ONE << STOP_BIT) | (ONE << VSEL_BIT) |
                                          (((ONE << SW_BITS) - ONE) << LINE_LO));

   logic cnt_wr, cmp_wr;
   assign cnt_wr = reg_we && (reg_sel == SEL_W'(SEL_CNT));
   assign cmp_wr = reg_we && (reg_sel == SEL_W'(SEL_CMP));

   a_r3_counts_when_running: assert property (@(posedge clk) disable iff (!rst_n)
      (!why_q[STOP_BIT] && !cnt_wr) |=> count_q == DATA_W'($past(count_q) + ONE));

   a_r3_holds_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (why_q[STOP_BIT] && !cnt_wr) |=> $stable(count_q));

   a_r4_write_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> count_q == $past(reg_wdata));

   a_r5_fixed_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> ((why_q ^ $past(why_q)) & KEEP) == '0);

   a_r6_pending_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_pend && !cmp_wr) |=> cmp_pend);

   a_r7_match_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr |=> !cmp_pend);

   a_r8_masked_at_exl: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[EXL_BIT] || !mode_q[IE_BIT]) |-> !irq_req);
endmodule

bind sctl_timer_irq sctl_timer_irq_chk #(
   .DATA_W   (DATA_W),
   .SEL_W    (SEL_W),
   .SEL_CNT  (SEL_CNT),
   .SEL_CMP  (SEL_CMP),
   .STOP_BIT (STOP_BIT),
   .VSEL_BIT (VSEL_BIT),
   .LINE_LO  (LINE_LO),
   .SW_BITS  (SW_BITS),
   .IE_BIT   (IE_BIT),
   .EXL_BIT  (EXL_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_sel   (reg_sel),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .irq_req   (irq_req),
   .count_q   (count_q),
   .why_q     (why_q),
   .mode_q    (mode_q),
   .cmp_pend  (cmp_pend)
);

// File: tb/sctl_timer_irq_bench.sv
module sctl_timer_irq_bench;
   localparam logic [4:0] S_CNT = 5'd9, S_CMP = 5'd11, S_MODE = 5'd12, S_WHY = 5'd13;

   typedef struct packed {
      logic        we;
      logic [4:0]  sel;
      logic [31:0] wdata;
      logic [4:0]  rsel;
      logic [31:0] exp_rd;
      logic        exp_irq;
      logic [11:0] exp_vec;
   } vec_t;

   // counter stays stopped throughout this table
   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{1'b1, S_MODE, 32'h1000_8001, S_MODE, 32'h1000_8001, 1'b0, 12'h200}, // R10
      '{1'b1, S_WHY,  32'hFFFF_FFFF, S_WHY,  32'h0880_037C, 1'b0, 12'h200}, // R5
      '{1'b1, S_MODE, 32'h1000_0301, S_MODE, 32'h1000_0301, 1'b1, 12'h200}, // R8 sw lines
      '{1'b1, S_MODE, 32'h1000_0303, S_MODE, 32'h1000_0303, 1'b0, 12'h200}, // R8 exl
      '{1'b1, S_WHY,  32'h0800_0000, S_WHY,  32'h0800_007C, 1'b0, 12'h180}, // R5 R9
      '{1'b1, S_CMP,  32'h0000_0055, S_CMP,  32'h0000_0055, 1'b0, 12'h180}, // R2
      '{1'b1, S_CNT,  32'h0000_1234, S_CNT,  32'h0000_1234, 1'b0, 12'h180}, // R4
      '{1'b1, S_WHY,  32'h0880_0300, S_WHY,  32'h0880_037C, 1'b0, 12'h200}, // R9
      '{1'b1, 5'd10,  32'h0000_DEAD, 5'd10,  32'h0000_0000, 1'b0, 12'h200}, // R2 unmapped
      '{1'b0, 5'd0,   32'h0000_0000, S_MODE, 32'h1000_0303, 1'b0, 12'h200}  // R2 no side effect
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_sel = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_req;
   logic [11:0] irq_vec_off;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sctl_timer_irq u_sctl_timer_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_sel     (reg_sel),
      .reg_we      (reg_we),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .irq_req     (irq_req),
      .irq_vec_off (irq_vec_off)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] sel, output logic [31:0] v);
      reg_sel = sel;
      #1;
      v = reg_rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, c1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(S_MODE, v); chk("R1 mode", v, 32'h1000_0002);
      rd(S_WHY, v);  chk("R1 reason", v, 32'h0880_007C);
      rd(S_CNT, v);  chk("R1 count", v, 32'h0);
      rd(S_CMP, v);  chk("R1 match", v, 32'h0);
      chk("R1 irq", {31'b0, irq_req}, 32'h0);
      chk("R9 reset vector", {20'b0, irq_vec_off}, 32'h200);
      repeat (4) @(negedge clk);
      rd(S_CNT, v);  chk("R3 stopped after reset", v, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (TBL[i].we) wr(TBL[i].sel, TBL[i].wdata);
         else @(negedge clk);
         rd(TBL[i].rsel, v);
         chk($sformatf("table row %0d read", i), v, TBL[i].exp_rd);
         chk($sformatf("table row %0d irq", i), {31'b0, irq_req}, {31'b0, TBL[i].exp_irq});
         chk($sformatf("table row %0d vector", i), {20'b0, irq_vec_off}, {20'b0, TBL[i].exp_vec});
      end

      // counting and match timing
      wr(S_MODE, 32'h1000_8001);
      wr(S_CMP, 32'd20);
      wr(S_CNT, 32'd0);
      wr(S_WHY, 32'h0080_0000);       // start counter
      rd(S_CNT, v); chk("R3 first cycle", v, 32'd0);
      repeat (5) @(negedge clk);
      rd(S_CNT, v); chk("R3 five clocks", v, 32'd5);
      repeat (15) @(negedge clk);
      rd(S_CNT, v); chk("R3 at match value", v, 32'd20);
      chk("R6 not yet pending", {31'b0, irq_req}, 32'h0);
      @(negedge clk);
      chk("R6 pending one edge later", {31'b0, irq_req}, 32'h1);
      rd(S_WHY, v); chk("R6 reason bit15", v, 32'h0080_807C);
      repeat (10) @(negedge clk);
      chk("R6 pending sticks", {31'b0, irq_req}, 32'h1);
      wr(S_CNT, 32'd100);
      rd(S_CNT, v); chk("R4 load beats increment", v, 32'd100);
      wr(S_CMP, 32'h1000);
      chk("R7 match write clears irq", {31'b0, irq_req}, 32'h0);
      rd(S_WHY, v); chk("R7 reason bit15 cleared", v, 32'h0080_007C);

      // stop again
      wr(S_WHY, 32'h0880_0000);
      rd(S_CNT, c1);
      repeat (5) @(negedge clk);
      rd(S_CNT, v); chk("R3 holds when stopped", v, c1);

      // match write coinciding with a match
      wr(S_CNT, 32'd30);
      wr(S_CMP, 32'd33);
      wr(S_WHY, 32'h0080_0000);
      @(negedge clk); @(negedge clk);
      rd(S_CNT, v); chk("R3 running to 32", v, 32'd32);
      wr(S_CMP, 32'd33);               // commits on the matching edge
      chk("R7 clear wins over match", {31'b0, irq_req}, 32'h0);
      repeat (3) @(negedge clk);
      rd(S_WHY, v); chk("R7 no late pending", v, 32'h0080_007C);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule